// File: doc/BRIEF.md
# Sector Cache with Per-Sub-Block Valid Bits

This block is a read-only, direct-mapped cache. Each line holds one tag, and each sub-block of the line has its own valid bit. A lookup counts as a hit only when the stored tag equals the request tag and the valid bit of the addressed sub-block is set. A matching tag alone is not enough. On a miss the cache asks memory for the one sub-block it needs, never the whole line. This keeps refill traffic small while the tag cost is still paid once per line.

The CPU side is a single read port. A request is taken when `req_valid` and `req_ready` are both high. A hit answers in the next cycle. A miss raises `busy` and holds a sub-block-aligned fetch request toward memory. When memory returns the whole sub-block, the cache installs it and answers one cycle later with the requested word. Addresses count words. A sub-block holds `SUB_WORDS` words, and the response carries the single word that the request named.

Top module: `sector_cache`

## Requirements
- R1: The word address splits, from the least significant bit upward, into a word-select field (log2 SUB_WORDS bits), a sub-block number (log2 NUM_SUBS bits), a line index (log2 NUM_LINES bits) and a tag (the remaining upper bits). With the defaults this is bit 0 word select, bits 2:1 sub-block, bits 6:3 index and bits 15:7 tag. Within a returned sub-block, word 0 sits in the least significant WORD_W bits.
- R2: A request whose tag equals the stored tag of its line, and whose sub-block valid bit is set, is a hit. In the cycle after it is accepted, `rsp_valid` is 1, `rsp_hit` is 1 and `rsp_data` is the cached word.
- R3: A request whose tag matches but whose sub-block valid bit is clear is a miss.
- R4: Each miss issues exactly one memory fetch, for the addressed sub-block only. `mem_req_addr` equals the request address with the word-select bits cleared, and it is held steady until `mem_rsp_valid`.
- R5: During a fill, `busy` is 1 and `req_ready` is 0. In the cycle after `mem_rsp_valid`, `busy` drops, and `rsp_valid` is 1 with `rsp_hit` 0 and `rsp_data` taken from the fetched sub-block.
- R6: A fill into a line whose tag differs from the request tag, or whose line holds no valid sub-block, writes the new tag, clears every other valid bit of that line and sets the fetched one.
- R7: A fill into a line whose tag matches keeps the tag and all other valid bits, and sets only the fetched sub-block's bit.
- R8: Reset clears every valid bit, so the first access to any address misses. After reset `req_ready` is 1, and `busy`, `rsp_valid` and `mem_req_valid` are 0.
- R9: A request offered in the same cycle that a response is presented is accepted and looked up against the state that includes any sub-block just installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU read request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Response word valid (one-cycle pulse) |
| rsp_hit | output | 1 | Response was served from the cache |
| rsp_data | output | WORD_W | Requested word |
| busy | output | 1 | A sub-block fill is in progress |
| mem_req_valid | output | 1 | Fetch request toward memory |
| mem_req_addr | output | ADDR_W | Sub-block-aligned fetch address |
| mem_rsp_valid | input | 1 | Memory returns the fetched sub-block (one-cycle pulse) |
| mem_rsp_data | input | WORD_W*SUB_WORDS | Fetched sub-block, word 0 in the low bits |

## Verification
In a single cycle the cache can present the response of a completed fill and also accept a new request. That request's lookup must see the sub-block installed at the same clock edge. The bench provokes this by offering the next request at the first falling edge where the fill response is visible. It does this both to the word next to the one just filled and to other sub-blocks of the same line. A scoreboard holds the expected hit flag and data, computed from a bench-side model of the tag and valid rules. Each expected item is compared against the response that arrives. For hits, the bench also checks that the response appears exactly one cycle after acceptance.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } sc_state_e;

endpackage

// File: rtl/sc_addr_split.sv
module sc_addr_split #(
    parameter int ADDR_W   = 16,
    parameter int WSEL_W   = 1,
    parameter int SUB_W    = 2,
    parameter int INDEX_W  = 4,
    parameter int TAG_W    = 9
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [WSEL_W-1:0]  wsel,
    output logic [SUB_W-1:0]   sub,
    output logic [INDEX_W-1:0] idx,
    output logic [TAG_W-1:0]   tag
);

    localparam int SUB_LO = WSEL_W;
    localparam int IDX_LO = WSEL_W + SUB_W;
    localparam int TAG_LO = WSEL_W + SUB_W + INDEX_W;

    initial begin
        if (TAG_LO + TAG_W != ADDR_W) $error("address fields do not cover the address");
    end

    always_comb begin
        wsel = addr[WSEL_W-1:0];
        sub  = addr[SUB_LO +: SUB_W];
        idx  = addr[IDX_LO +: INDEX_W];
        tag  = addr[TAG_LO +: TAG_W];
    end

endmodule

// File: rtl/sc_tag_valid_store.sv
module sc_tag_valid_store #(
    parameter int NUM_LINES = 16,
    parameter int NUM_SUBS  = 4,
    parameter int TAG_W     = 9,
    parameter int INDEX_W   = 4,
    parameter int SUB_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [INDEX_W-1:0] lk_idx,
    input  logic [SUB_W-1:0]   lk_sub,
    output logic               lk_hit,
    input  logic               fl_en,
    input  logic [TAG_W-1:0]   fl_tag,
    input  logic [INDEX_W-1:0] fl_idx,
    input  logic [SUB_W-1:0]   fl_sub
);

    typedef struct packed {
        logic [NUM_LINES-1:0][TAG_W-1:0]    tags;
        logic [NUM_LINES-1:0][NUM_SUBS-1:0] vld;
    } tv_state_t;

    tv_state_t st_d, st_q;
    logic [NUM_LINES-1:0] line_tag_eq;
    logic                 fl_replace;

    // one tag comparator per line; the lookup index picks one result
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        assign line_tag_eq[g] = (st_q.tags[g] == lk_tag);
    end

    always_comb begin
        lk_hit = line_tag_eq[lk_idx] && st_q.vld[lk_idx][lk_sub];
    end

    always_comb begin
        st_d       = st_q;
        fl_replace = (st_q.tags[fl_idx] != fl_tag) || (st_q.vld[fl_idx] == '0);
        if (fl_en) begin
            if (fl_replace) begin
                st_d.tags[fl_idx] = fl_tag;
                st_d.vld[fl_idx]  = '0;
            end
            st_d.vld[fl_idx][fl_sub] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a replacing fill leaves exactly one valid sub-block and the new tag
    a_r6_replace_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && fl_replace) |=> ($countones(st_q.vld[$past(fl_idx)]) == 1)
                                  && (st_q.tags[$past(fl_idx)] == $past(fl_tag)));

    // R7: a tag-matching fill keeps the older bits and the tag
    a_r7_merge_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !fl_replace) |=> ((st_q.vld[$past(fl_idx)] & $past(st_q.vld[fl_idx]))
                                     == $past(st_q.vld[fl_idx]))
                                    && $stable(st_q.tags));

    // R8: valid bits change only on a fill
    a_r8_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_en |=> $stable(st_q.vld));

endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
    parameter int NUM_LINES = 16,
    parameter int NUM_SUBS  = 4,
    parameter int SUB_BITS  = 64,
    parameter int INDEX_W   = 4,
    parameter int SUB_W     = 2
) (
    input  logic                clk,
    input  logic [INDEX_W-1:0]  rd_idx,
    input  logic [SUB_W-1:0]    rd_sub,
    output logic [SUB_BITS-1:0] rd_data,
    input  logic                wr_en,
    input  logic [INDEX_W-1:0]  wr_idx,
    input  logic [SUB_W-1:0]    wr_sub,
    input  logic [SUB_BITS-1:0] wr_data
);

    logic [NUM_LINES-1:0][NUM_SUBS-1:0][SUB_BITS-1:0] mem_d, mem_q;

    always_comb begin
        rd_data = mem_q[rd_idx][rd_sub];
    end

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx][wr_sub] = wr_data;
        end
    end

    // storage only; valid bits gate every read that matters
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int SUB_WORDS = 2,
    parameter int WSEL_W    = 1,
    parameter int SUB_W     = 2,
    parameter int INDEX_W   = 4,
    parameter int TAG_W     = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [WSEL_W-1:0]             req_wsel,
    input  logic [SUB_W-1:0]              req_sub,
    input  logic [INDEX_W-1:0]            req_idx,
    input  logic [TAG_W-1:0]              req_tag,
    input  logic                          lk_hit,
    input  logic [WORD_W*SUB_WORDS-1:0]   rd_sub_data,
    output logic                          busy,
    output logic                          mem_req_valid,
    output logic [ADDR_W-1:0]             mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [WORD_W*SUB_WORDS-1:0]   mem_rsp_data,
    output logic                          fl_en,
    output logic [TAG_W-1:0]              fl_tag,
    output logic [INDEX_W-1:0]            fl_idx,
    output logic [SUB_W-1:0]              fl_sub,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic [WORD_W-1:0]             rsp_data
);

    typedef struct packed {
        sc_state_e          state;
        logic [TAG_W-1:0]   p_tag;
        logic [INDEX_W-1:0] p_idx;
        logic [SUB_W-1:0]   p_sub;
        logic [WSEL_W-1:0]  p_wsel;
        logic               rsp_valid;
        logic               rsp_hit;
        logic [WORD_W-1:0]  rsp_data;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  accept;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        accept          = (ctl_q.state == ST_IDLE) && req_valid;
        fl_en           = (ctl_q.state == ST_FILL) && mem_rsp_valid;

        if (accept) begin
            ctl_d.p_tag  = req_tag;
            ctl_d.p_idx  = req_idx;
            ctl_d.p_sub  = req_sub;
            ctl_d.p_wsel = req_wsel;
            if (lk_hit) begin
                ctl_d.rsp_valid = 1'b1;
                ctl_d.rsp_hit   = 1'b1;
                ctl_d.rsp_data  = rd_sub_data[req_wsel*WORD_W +: WORD_W];
            end else begin
                ctl_d.state = ST_FILL;
            end
        end

        if (fl_en) begin
            ctl_d.rsp_valid = 1'b1;
            ctl_d.rsp_hit   = 1'b0;
            ctl_d.rsp_data  = mem_rsp_data[ctl_q.p_wsel*WORD_W +: WORD_W];
            ctl_d.state     = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        req_ready     = (ctl_q.state == ST_IDLE);
        busy          = (ctl_q.state == ST_FILL);
        mem_req_valid = (ctl_q.state == ST_FILL);
        mem_req_addr  = {ctl_q.p_tag, ctl_q.p_idx, ctl_q.p_sub, {WSEL_W{1'b0}}};
        fl_tag        = ctl_q.p_tag;
        fl_idx        = ctl_q.p_idx;
        fl_sub        = ctl_q.p_sub;
        rsp_valid     = ctl_q.rsp_valid;
        rsp_hit       = ctl_q.rsp_hit;
        rsp_data      = ctl_q.rsp_data;
    end

    // R2: an accepted hit answers in the following cycle
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (rsp_valid && rsp_hit && !busy));

    // R5: an accepted miss starts a fill with no response yet
    a_r5_miss_enters_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lk_hit) |=> (busy && !rsp_valid && !req_ready));

    // R5: the memory response ends the fill with a miss response
    a_r5_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rsp_valid) |=> (!busy && rsp_valid && !rsp_hit));

    // R4: the fetch stays up with a steady address until memory answers
    a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: rtl/sector_cache.sv
module sector_cache #(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int SUB_WORDS = 2,
    parameter int NUM_SUBS  = 4,
    parameter int NUM_LINES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic [WORD_W-1:0]           rsp_data,
    output logic                        busy,
    output logic                        mem_req_valid,
    output logic [ADDR_W-1:0]           mem_req_addr,
    input  logic                        mem_rsp_valid,
    input  logic [WORD_W*SUB_WORDS-1:0] mem_rsp_data
);

    localparam int WSEL_W   = (SUB_WORDS > 1) ? $clog2(SUB_WORDS) : 1;
    localparam int SUB_W    = (NUM_SUBS  > 1) ? $clog2(NUM_SUBS)  : 1;
    localparam int INDEX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int TAG_W    = ADDR_W - WSEL_W - SUB_W - INDEX_W;
    localparam int SUB_BITS = WORD_W * SUB_WORDS;

    logic [WSEL_W-1:0]   lk_wsel;
    logic [SUB_W-1:0]    lk_sub;
    logic [INDEX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]    lk_tag;
    logic                lk_hit;
    logic [SUB_BITS-1:0] rd_sub_data;
    logic                fl_en;
    logic [TAG_W-1:0]    fl_tag;
    logic [INDEX_W-1:0]  fl_idx;
    logic [SUB_W-1:0]    fl_sub;

    sc_addr_split #(
        .ADDR_W (ADDR_W),
        .WSEL_W (WSEL_W),
        .SUB_W  (SUB_W),
        .INDEX_W(INDEX_W),
        .TAG_W  (TAG_W)
    ) u_split (
        .addr(req_addr),
        .wsel(lk_wsel),
        .sub (lk_sub),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    sc_tag_valid_store #(
        .NUM_LINES(NUM_LINES),
        .NUM_SUBS (NUM_SUBS),
        .TAG_W    (TAG_W),
        .INDEX_W  (INDEX_W),
        .SUB_W    (SUB_W)
    ) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .lk_tag(lk_tag),
        .lk_idx(lk_idx),
        .lk_sub(lk_sub),
        .lk_hit(lk_hit),
        .fl_en (fl_en),
        .fl_tag(fl_tag),
        .fl_idx(fl_idx),
        .fl_sub(fl_sub)
    );

    sc_data_store #(
        .NUM_LINES(NUM_LINES),
        .NUM_SUBS (NUM_SUBS),
        .SUB_BITS (SUB_BITS),
        .INDEX_W  (INDEX_W),
        .SUB_W    (SUB_W)
    ) u_data (
        .clk    (clk),
        .rd_idx (lk_idx),
        .rd_sub (lk_sub),
        .rd_data(rd_sub_data),
        .wr_en  (fl_en),
        .wr_idx (fl_idx),
        .wr_sub (fl_sub),
        .wr_data(mem_rsp_data)
    );

    sc_ctrl #(
        .ADDR_W   (ADDR_W),
        .WORD_W   (WORD_W),
        .SUB_WORDS(SUB_WORDS),
        .WSEL_W   (WSEL_W),
        .SUB_W    (SUB_W),
        .INDEX_W  (INDEX_W),
        .TAG_W    (TAG_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_wsel     (lk_wsel),
        .req_sub      (lk_sub),
        .req_idx      (lk_idx),
        .req_tag      (lk_tag),
        .lk_hit       (lk_hit),
        .rd_sub_data  (rd_sub_data),
        .busy         (busy),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .fl_en        (fl_en),
        .fl_tag       (fl_tag),
        .fl_idx       (fl_idx),
        .fl_sub       (fl_sub),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_data     (rsp_data)
    );

    // R8: right after reset nothing is in flight
    a_r8_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (req_ready && !busy && !rsp_valid && !mem_req_valid));

endmodule

// File: tb/sector_cache_tb_top.sv
module sector_cache_tb_top;

    localparam int ADDR_W = 16;
    localparam int WORD_W = 32;
    localparam int SUBW   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [WORD_W-1:0] rsp_data;
    logic              busy;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [WORD_W*SUBW-1:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    sector_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [WORD_W-1:0] data;
        logic              hit;
        int                cyc;
        string             tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   misses_exp = 0;
    int   fetches = 0;
    bit   done = 0;

    logic [8:0] m_tag [16];
    logic [3:0] m_vld [16];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [WORD_W-1:0] mem_word(logic [ADDR_W-1:0] a);
        return {a ^ 16'hC3A5, a + 16'h1111};
    endfunction

    function automatic logic [ADDR_W-1:0] mk(int tg, int ix, int sb, int w);
        return {tg[8:0], ix[3:0], sb[1:0], w[0]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: R1 field layout bit0 word, bits2:1 sub, bits6:3 index, bits15:7 tag
    task automatic issue(logic [ADDR_W-1:0] a, string req);
        exp_t e;
        int ix;
        int sb;
        while (!req_ready) @(negedge clk);
        ix = int'(a[6:3]);
        sb = int'(a[2:1]);
        e.hit = (m_tag[ix] == a[15:7]) && m_vld[ix][sb];
        if (!e.hit) begin
            misses_exp++;
            if (m_tag[ix] != a[15:7] || m_vld[ix] == 4'b0) begin
                m_tag[ix] = a[15:7];
                m_vld[ix] = 4'b0;
            end
            m_vld[ix][sb] = 1'b1;
        end
        e.data = mem_word(a);
        e.cyc  = cyc;
        e.tag  = req;
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", 64'(rsp_data), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_hit == e.hit, e.tag, "hit flag", 64'(rsp_hit), 64'(e.hit));
                chk(rsp_data == e.data, e.tag, "data", 64'(rsp_data), 64'(e.data));
                if (e.hit) chk(cyc == e.cyc + 1, "R2", "hit latency", 64'(cyc), 64'(e.cyc + 1));
            end
        end
    end

    // memory model
    int lat_cnt = 0;
    bit pending = 0;
    always @(negedge clk) begin
        if (mem_rsp_valid) begin
            mem_rsp_valid <= 1'b0;
            pending = 0;
        end else if (pending) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= {mem_word(mem_req_addr + 16'd1), mem_word(mem_req_addr)};
                chk(busy && !req_ready, "R5", "busy during fill", 64'({busy, req_ready}), 64'b10);
            end
        end else if (rst_n && mem_req_valid) begin
            fetches++;
            pending = 1;
            lat_cnt = 1 + int'($urandom_range(0, 3));
            chk(mem_req_addr[0] == 1'b0, "R4", "fetch alignment", 64'(mem_req_addr), 64'(mem_req_addr & 16'hFFFE));
            chk(busy && !req_ready, "R5", "busy at fetch", 64'({busy, req_ready}), 64'b10);
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_tag[i] = '0;
            m_vld[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle outputs after reset
        chk(req_ready == 1'b1, "R8", "ready after reset", 64'(req_ready), 64'd1);
        chk(busy == 1'b0, "R8", "busy after reset", 64'(busy), 64'd0);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R8", "fetch after reset", 64'(mem_req_valid), 64'd0);

        // directed sequence on line 5, tags 3 and 26
        issue(mk(3, 5, 0, 0), "R8");   // first access misses
        issue(mk(3, 5, 0, 1), "R9");   // offered as the fill response shows; hits other word (R1)
        issue(mk(3, 5, 1, 0), "R3");   // tag matches, sub-block invalid
        issue(mk(3, 5, 0, 0), "R7");   // earlier sub-block kept
        issue(mk(3, 5, 1, 1), "R7");
        issue(mk(26, 5, 2, 1), "R6");  // new tag replaces line
        issue(mk(26, 5, 0, 0), "R6");  // old sub-block cleared
        issue(mk(26, 5, 2, 0), "R7");
        issue(mk(3, 5, 1, 0), "R6");
        issue(mk(3, 5, 1, 1), "R9");
        issue(mk(3, 5, 2, 1), "R6");   // sub 2 cleared when tag 3 returned

        // mixed traffic over a small footprint
        for (int n = 0; n < 400; n++) begin
            issue(mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 3)), int'($urandom_range(0, 1))), "R2");
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(fetches == misses_exp, "R4", "fetch count", 64'(fetches), 64'(misses_exp));
        finish_up();
    end

endmodule